// File: doc/BRIEF.md
# Serial audio receive slot formatter

This block receives one data slot of a frame-synchronised serial audio stream and delivers it as a formatted 32-bit parallel word. It runs on the system clock. A one-cycle bit-clock enable marks the cycles on which the serial line and the frame-sync strobe are looked at. A static configuration selects four things: the gap between frame sync and the first data bit, the order in which bits arrive, the slot length, and how the output positions that carry no data get filled.

The received bits are first placed into a data word. They are placed directly for a least-significant-first stream, and mirrored within the slot for a most-significant-first stream. Each output position then takes either its data bit or a pad value. A position takes its data bit only when its mask bit is set and it lies inside the slot. The pad value is a constant, or a copy of one selectable bit of the data word. The finished word is presented with a single-cycle valid pulse and is held until the next word.

Top module: `aud_slot_rx`

## Requirements
- R1: After reset, `word_out` is 0 and `word_valid` is 0. With all configuration inputs at 0, `cfg_err` is 0.
- R2: With `cfg_delay` = 0, the enabled cycle that carries the frame-sync pulse also carries data bit 0 of the slot.
- R3: With `cfg_delay` = 1 or 2, data bit 0 arrives on the first or the second enabled cycle after the frame-sync cycle. Each following enabled cycle carries the next bit.
- R4: With `cfg_delay` = 3, `cfg_err` is 1, no slot is captured and `word_valid` stays 0.
- R5: With `cfg_msb_first` = 0, the k-th received bit (k from 0) goes to data-word position k.
- R6: With `cfg_msb_first` = 1, the k-th received bit goes to position L-1-k, where L is the slot length.
- R7: Output position i carries data-word bit i exactly when `cfg_mask[i]` = 1 and i < L. Every other position carries the pad value.
- R8: The pad value is set by `cfg_pad_mode`: 0 for code 0, 1 for code 1, and 0 for the reserved code 3.
- R9: With `cfg_pad_mode` = 2, the pad value is data-word bit `cfg_pad_idx`. The index counts positions after any mirroring. Data-word positions at or above L read as 0.
- R10: The slot length is L = 8 + 4*`cfg_slot_len` for codes 0 to 6. Code 7 also gives 32.
- R11: `word_valid` is high for exactly one cycle. It appears on the cycle after the enabled cycle that carries the last bit. `word_out` changes only together with a valid pulse.
- R12: A frame-sync pulse on an enabled cycle in the middle of a slot discards the partial word without a valid pulse and starts a new slot under the current delay. This includes a pulse on the cycle that would have carried the last bit.
- R13: On cycles with `bit_en` = 0, both `fsync` and `sdata` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable, one system cycle wide |
| fsync | input | 1 | Frame-sync strobe, looked at on enabled cycles |
| sdata | input | 1 | Serial data bit |
| cfg_delay | input | 2 | Data delay after frame sync: 0, 1, 2 cycles, 3 reserved |
| cfg_msb_first | input | 1 | 1 when the stream arrives most-significant bit first |
| cfg_pad_mode | input | 2 | Pad source: 0 zero, 1 one, 2 selected bit, 3 zero |
| cfg_pad_idx | input | 5 | Data-word bit copied into pad positions in mode 2 |
| cfg_mask | input | 32 | 1 marks an output position that carries data |
| cfg_slot_len | input | 3 | Slot length code, L = 8 + 4*code, capped at 32 |
| word_out | output | 32 | Formatted word of the last completed slot |
| word_valid | output | 1 | One-cycle pulse when a new word is presented |
| cfg_err | output | 1 | High while the reserved delay code is selected |

## Verification
Frame-sync handling and slot completion can fall on the same enabled cycle: a new frame-sync pulse can arrive exactly where the last bit of the running slot was due. The bench provokes this by driving a slot one bit short and then starting a fresh slot at once. It judges the outcome by the count of valid pulses and by the word delivered: the fresh slot must win, and the partial slot must produce nothing. With zero delay, the frame-sync cycle also doubles as the bit-0 sample. This case is covered by every zero-delay slot of the sweep, and the disabled cycles between bits carry a high frame sync that must be ignored.

// File: rtl/aud_slot_pkg.sv
package aud_slot_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int CNT_W  = IDX_W + 1;
    localparam int LEN_CODE_W = 3;
    localparam int DLY_W  = 2;

    typedef enum logic [1:0] {
        PAD_ZERO = 2'd0,
        PAD_ONE  = 2'd1,
        PAD_SEL  = 2'd2,
        PAD_RSVD = 2'd3
    } pad_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CAPT = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic              msb_first;
        pad_mode_e         pad_mode;
        logic [IDX_W-1:0]  pad_idx;
        logic [WORD_W-1:0] mask;
        logic [CNT_W-1:0]  len;
    } fmt_cfg_t;

    typedef struct packed {
        logic             samp;
        logic             last;
        logic             clr;
        logic [CNT_W-1:0] idx;
    } samp_ctl_t;

    function automatic logic [CNT_W-1:0] slot_len(input logic [LEN_CODE_W-1:0] code);
        int unsigned l;
        l = 8 + 4 * int'(code);
        if (l > WORD_W) l = WORD_W;
        return CNT_W'(l);
    endfunction

    function automatic logic [IDX_W-1:0] slot_pos(input logic [CNT_W-1:0] k,
                                                  input logic [CNT_W-1:0] len,
                                                  input logic msb_first);
        logic [CNT_W-1:0] p;
        p = msb_first ? (len - CNT_W'(1) - k) : k;
        return p[IDX_W-1:0];
    endfunction

    function automatic logic pad_value(input pad_mode_e mode,
                                       input logic [WORD_W-1:0] data,
                                       input logic [IDX_W-1:0] idx);
        logic v;
        case (mode)
            PAD_ONE: v = 1'b1;
            PAD_SEL: v = data[idx];
            default: v = 1'b0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/aud_slot_align.sv
module aud_slot_align
    import aud_slot_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bit_en,
    input  logic                   fsync,
    input  logic [DLY_W-1:0]       cfg_delay,
    input  logic [CNT_W-1:0]       len,
    output samp_ctl_t              ctl,
    output logic                   cfg_err
);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [DLY_W-1:0] wait_q, wait_d;
    logic             samp;
    logic             clr;
    logic [CNT_W-1:0] idx;

    assign cfg_err = (cfg_delay == DLY_W'(3));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wait_d  = wait_q;
        samp    = 1'b0;
        clr     = 1'b0;
        idx     = cnt_q;
        if (cfg_err) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            wait_d  = '0;
        end else if (bit_en) begin
            if (fsync) begin
                clr = 1'b1;
                if (cfg_delay == '0) begin
                    samp    = 1'b1;
                    idx     = '0;
                    state_d = ST_CAPT;
                    cnt_d   = CNT_W'(1);
                end else begin
                    state_d = ST_WAIT;
                    wait_d  = cfg_delay - DLY_W'(1);
                    cnt_d   = '0;
                end
            end else begin
                case (state_q)
                    ST_WAIT: begin
                        if (wait_q == '0) begin
                            samp    = 1'b1;
                            idx     = '0;
                            state_d = ST_CAPT;
                            cnt_d   = CNT_W'(1);
                        end else begin
                            wait_d = wait_q - DLY_W'(1);
                        end
                    end
                    ST_CAPT: begin
                        samp = 1'b1;
                        idx  = cnt_q;
                        if (cnt_q == len - CNT_W'(1)) begin
                            state_d = ST_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        ctl.samp = samp;
        ctl.clr  = clr;
        ctl.idx  = idx;
        ctl.last = samp && (idx == len - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wait_q  <= wait_d;
        end
    end

endmodule

// File: rtl/aud_slot_capture.sv
module aud_slot_capture
    import aud_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              samp,
    input  logic              clr,
    input  logic              sdata,
    input  logic [IDX_W-1:0]  pos,
    output logic [WORD_W-1:0] data_next
);

    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] base;

    assign base = clr ? '0 : acc_q;

    generate
        for (genvar i = 0; i < WORD_W; i++) begin : g_bit
            always_comb begin
                if (samp && (pos == IDX_W'(i)))
                    data_next[i] = sdata;
                else
                    data_next[i] = base[i];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (samp || clr)
            acc_q <= data_next;
    end

endmodule

// File: rtl/aud_slot_format.sv
module aud_slot_format
    import aud_slot_pkg::*;
(
    input  fmt_cfg_t          cfg,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] word
);

    logic pad;

    assign pad = pad_value(cfg.pad_mode, data, cfg.pad_idx);

    generate
        for (genvar i = 0; i < WORD_W; i++) begin : g_pos
            logic in_slot;
            assign in_slot = (CNT_W'(i) < cfg.len);
            assign word[i] = (cfg.mask[i] && in_slot) ? data[i] : pad;
        end
    endgenerate

endmodule

// File: rtl/aud_slot_rx.sv
module aud_slot_rx
    import aud_slot_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_en,
    input  logic        fsync,
    input  logic        sdata,
    input  logic [1:0]  cfg_delay,
    input  logic        cfg_msb_first,
    input  logic [1:0]  cfg_pad_mode,
    input  logic [4:0]  cfg_pad_idx,
    input  logic [31:0] cfg_mask,
    input  logic [2:0]  cfg_slot_len,
    output logic [31:0] word_out,
    output logic        word_valid,
    output logic        cfg_err
);

    fmt_cfg_t          fcfg;
    samp_ctl_t         ctl;
    logic [IDX_W-1:0]  pos;
    logic [WORD_W-1:0] data_next;
    logic [WORD_W-1:0] fmt_word;

    always_comb begin
        fcfg.msb_first = cfg_msb_first;
        fcfg.pad_mode  = pad_mode_e'(cfg_pad_mode);
        fcfg.pad_idx   = cfg_pad_idx;
        fcfg.mask      = cfg_mask;
        fcfg.len       = slot_len(cfg_slot_len);
    end

    aud_slot_align u_align (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .fsync     (fsync),
        .cfg_delay (cfg_delay),
        .len       (fcfg.len),
        .ctl       (ctl),
        .cfg_err   (cfg_err)
    );

    assign pos = slot_pos(ctl.idx, fcfg.len, fcfg.msb_first);

    aud_slot_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .samp      (ctl.samp),
        .clr       (ctl.clr),
        .sdata     (sdata),
        .pos       (pos),
        .data_next (data_next)
    );

    aud_slot_format u_fmt (
        .cfg  (fcfg),
        .data (data_next),
        .word (fmt_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out   <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= ctl.last;
            if (ctl.last)
                word_out <= fmt_word;
        end
    end

endmodule

// File: rtl/aud_slot_chk.sv
module aud_slot_chk (
    input logic        clk,
    input logic        rst,
    input logic        bit_en,
    input logic [1:0]  cfg_delay,
    input logic [1:0]  cfg_pad_mode,
    input logic [31:0] cfg_mask,
    input logic [31:0] word_out,
    input logic        word_valid,
    input logic        cfg_err
);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    a_r11_word_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(word_out) |-> word_valid);

    a_r13_valid_after_enable: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(bit_en));

    a_r4_reserved_delay: assert property (@(posedge clk) disable iff (rst)
        (cfg_delay == 2'd3) |=> !word_valid);

    a_r4_err_flag: assert property (@(posedge clk) disable iff (rst)
        cfg_err == (cfg_delay == 2'd3));

    a_r8_pad_one: assert property (@(posedge clk) disable iff (rst)
        $rose(word_valid) && $past(cfg_pad_mode == 2'd1 && cfg_mask == 32'd0)
        |-> word_out == 32'hFFFF_FFFF);

    a_r8_pad_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(word_valid) && $past(cfg_pad_mode == 2'd0 && cfg_mask == 32'd0)
        |-> word_out == 32'd0);

endmodule

bind aud_slot_rx aud_slot_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bit_en       (bit_en),
    .cfg_delay    (cfg_delay),
    .cfg_pad_mode (cfg_pad_mode),
    .cfg_mask     (cfg_mask),
    .word_out     (word_out),
    .word_valid   (word_valid),
    .cfg_err      (cfg_err)
);

// File: tb/tb_aud_slot_rx.sv
`timescale 1ns/1ps
module tb_aud_slot_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        fsync = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  cfg_delay = 2'd0;
    logic        cfg_msb_first = 1'b0;
    logic [1:0]  cfg_pad_mode = 2'd0;
    logic [4:0]  cfg_pad_idx = 5'd0;
    logic [31:0] cfg_mask = 32'd0;
    logic [2:0]  cfg_slot_len = 3'd0;
    logic [31:0] word_out;
    logic        word_valid;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    bit done = 0;

    always #4 clk = ~clk;

    aud_slot_rx dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .fsync(fsync), .sdata(sdata),
        .cfg_delay(cfg_delay), .cfg_msb_first(cfg_msb_first),
        .cfg_pad_mode(cfg_pad_mode), .cfg_pad_idx(cfg_pad_idx),
        .cfg_mask(cfg_mask), .cfg_slot_len(cfg_slot_len),
        .word_out(word_out), .word_valid(word_valid), .cfg_err(cfg_err)
    );

    always @(negedge clk) if (word_valid) vcount++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic rbit();
        return logic'($urandom & 1);
    endfunction

    task automatic tick(input logic en, input logic fs, input logic sd);
        @(negedge clk);
        bit_en = en; fsync = fs; sdata = sd;
        @(posedge clk);
        #1;
    endtask

    task automatic gap();
        tick(1'b0, 1'b1, rbit());
    endtask

    function automatic int len_of(input logic [2:0] code);
        int l;
        l = 8 + 4 * int'(code);
        return (l > 32) ? 32 : l;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] s, input int l, input logic msb,
                                          input logic [1:0] mode, input logic [4:0] idx,
                                          input logic [31:0] mask);
        logic [31:0] d, e;
        logic pb;
        d = '0;
        for (int k = 0; k < l; k++) d[msb ? (l - 1 - k) : k] = s[k];
        pb = (mode == 2'd1) ? 1'b1 : (mode == 2'd2) ? d[idx] : 1'b0;
        for (int i = 0; i < 32; i++) e[i] = (i < l && mask[i]) ? d[i] : pb;
        return e;
    endfunction

    task automatic drive_slot(input int d, input logic [31:0] s, input int nb);
        int k;
        k = 0;
        tick(1'b1, 1'b1, (d == 0) ? s[0] : rbit());
        if (d == 0) k = 1;
        for (int j = 1; j < d; j++) begin gap(); tick(1'b1, 1'b0, rbit()); end
        while (k < nb) begin gap(); tick(1'b1, 1'b0, s[k]); k++; end
    endtask

    task automatic run_slot(input logic [31:0] s, input string req, input int v0);
        logic [31:0] exp;
        int l;
        l = len_of(cfg_slot_len);
        exp = model(s, l, cfg_msb_first, cfg_pad_mode, cfg_pad_idx, cfg_mask);
        drive_slot(int'(cfg_delay), s, l);
        chk(word_valid === 1'b1, {req, " R11 valid after last bit"}, 32'(word_valid), 32'd1);
        chk(vcount == v0, {req, " R12 no early valid"}, 32'(vcount), 32'(v0));
        chk(word_out === exp, req, word_out, exp);
        gap();
        chk(word_valid === 1'b0, {req, " R11 one-cycle pulse"}, 32'(word_valid), 32'd0);
        chk(word_out === exp, {req, " R11 word held"}, word_out, exp);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        int v0;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        chk(word_out === 32'd0, "R1 reset word", word_out, 32'd0);
        chk(word_valid === 1'b0, "R1 reset valid", 32'(word_valid), 32'd0);
        chk(cfg_err === 1'b0, "R1 reset cfg_err", 32'(cfg_err), 32'd0);

        // Directed: R2 R5 R7 with full mask, 32-bit slot, LSB first
        cfg_mask = 32'hFFFF_FFFF; cfg_slot_len = 3'd7; cfg_delay = 2'd0;
        s = 32'hA5C3_1E69;
        run_slot(s, "R2 R5 R10 direct lsb", vcount);
        chk(word_out === s, "R5 identity", word_out, s);
        cfg_msb_first = 1'b1;
        run_slot(s, "R6 direct msb", vcount);
        cfg_delay = 2'd2;
        run_slot(s, "R3 delay2 msb", vcount);
        cfg_msb_first = 1'b0; cfg_delay = 2'd1;
        run_slot(s, "R3 delay1", vcount);

        // Sweep over delay, order, pad mode and slot length
        for (int d = 0; d < 3; d++)
            for (int m = 0; m < 2; m++)
                for (int p = 0; p < 4; p++)
                    for (int c = 0; c < 8; c++) begin
                        cfg_delay = 2'(d); cfg_msb_first = 1'(m);
                        cfg_pad_mode = 2'(p); cfg_slot_len = 3'(c);
                        cfg_pad_idx = 5'($urandom);
                        cfg_mask = (c == 0) ? 32'd0 : (c == 1) ? 32'hFFFF_FFFF : $urandom;
                        s = $urandom;
                        run_slot(s, "R3 R6 R7 R8 R9 R10 sweep", vcount);
                    end

        // R9: pad index pointing outside the slot reads 0
        cfg_delay = 2'd0; cfg_msb_first = 1'b0; cfg_pad_mode = 2'd2;
        cfg_slot_len = 3'd0; cfg_mask = 32'h0000_000F; cfg_pad_idx = 5'd20;
        run_slot(32'hFFFF_FFFF, "R9 idx outside slot", vcount);
        chk(word_out === 32'h0000_000F, "R9 outside pad zero", word_out, 32'h0000_000F);
        cfg_pad_idx = 5'd5;
        run_slot(32'h0000_0020, "R9 idx inside slot", vcount);
        chk(word_out === 32'hFFFF_FFF0, "R9 inside pad copy", word_out, 32'hFFFF_FFF0);

        // R12: abort at mid slot and at the last-bit cycle
        cfg_pad_mode = 2'd0; cfg_mask = 32'hFFFF_FFFF; cfg_slot_len = 3'd2;
        for (int d = 0; d < 3; d++) begin
            cfg_delay = 2'(d);
            v0 = vcount;
            drive_slot(d, $urandom, 7);
            gap();
            run_slot($urandom, "R12 abort mid", v0);
            v0 = vcount;
            drive_slot(d, $urandom, 15);
            gap();
            run_slot($urandom, "R12 abort at last bit", v0);
        end

        // R4: reserved delay code
        cfg_delay = 2'd3;
        @(posedge clk); #1;
        chk(cfg_err === 1'b1, "R4 cfg_err", 32'(cfg_err), 32'd1);
        v0 = vcount;
        for (int k = 0; k < 40; k++) tick(1'b1, (k % 9) == 0, rbit());
        gap(); gap();
        chk(vcount == v0, "R4 no capture", 32'(vcount), 32'(v0));
        cfg_delay = 2'd0;
        @(posedge clk); #1;
        chk(cfg_err === 1'b0, "R4 cfg_err clear", 32'(cfg_err), 32'd0);

        // R13: disabled cycles with fsync and data toggling produce nothing
        v0 = vcount;
        for (int k = 0; k < 60; k++) tick(1'b0, 1'b1, rbit());
        chk(vcount == v0, "R13 ignored while disabled", 32'(vcount), 32'(v0));
        run_slot(32'h0000_5A3C, "R13 slot after disabled run", vcount);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule